// File: doc/BRIEF.md
# Wide Word Memory Read Streamer

This block serves a host command that reads a run of 36-bit words from a sample memory and returns them as a stream of whole bytes. The command arrives as five 16-bit words on a valid/ready port. The first is the command code. Then come a 32-bit start address and a 32-bit word count. Each 32-bit value is sent as its upper 16-bit half first, then its lower half.

Once a command is complete, the block reads the words in pairs through a synchronous memory port with one cycle of read latency. Each pair forms a 72-bit unit, and the unit leaves as nine bytes, least significant byte first. The output stream honours backpressure and marks its final byte. The 72-bit unit is the smallest whole number of bytes made of 36-bit words, so an odd count is refused: the block sends nothing and pulses an error flag.

Top module: `wide_word_read_streamer`

## Requirements
- R1: The command is five words on `cmd_word`: the code 0x0006, then address bits [31:16], address bits [15:0], count bits [31:16] and count bits [15:0]. A word that arrives when a code is expected and is not 0x0006 is dropped, and parsing keeps waiting for the code.
- R2: `cmd_ready` is high when the block is idle. It is low from the cycle after the final command word is accepted until the last response byte has been accepted.
- R3: Words are fetched in pairs from address A (first) and A+1 (second). The pair forms the unit {second, first}, with the first word in bits [35:0]. The unit is sent as 9 bytes, bits [7:0] first. A count N yields exactly 9·N/2 bytes (36·N bits).
- R4: `out_last` is high on the final byte of a response and low on every other byte.
- R5: An odd count sends no bytes and makes no memory reads. `err_pulse` is high for exactly one cycle: it rises at the first clock edge after the edge that accepts the final command word.
- R6: A count of zero sends no bytes and raises no error.
- R7: Only address bits [17:0] are used (256K words). Successive word addresses wrap from 0x3FFFF to 0x00000.
- R8: While `out_valid` is high and `out_ready` is low, `out_byte` and `out_last` hold their values.
- R9: The first byte becomes valid at the fourth clock edge after the edge that accepts the final command word. After the last byte of a pair is accepted, the next pair's first byte appears three edges later. `mem_rd_en` is high for the two consecutive cycles that fetch a pair, and low otherwise.
- R10: After reset, `cmd_ready` is 1 and `out_valid`, `out_last`, `mem_rd_en` and `err_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Block accepts a command word |
| cmd_word | input | 16 | Command word |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 18 | Memory word address |
| mem_rd_data | input | 36 | Read data, valid the cycle after the strobe |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Receiver accepts the byte |
| out_byte | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the response |
| err_pulse | output | 1 | One-cycle pulse on a rejected odd count |

## Verification
Each result has a set arrival time, measured in clock edges from the edge that accepts the fifth command word. The error pulse is due one edge later and gone one edge after that. The first byte is due four edges later, and each new pair's first byte comes three edges after the previous pair ends. The bench drives on the falling edge and counts falling edges from the handshake. It checks the error flag and the first byte's arrival at exactly those counts, and it compares each byte only in a cycle where valid and ready are both high. A behavioural memory model in the bench returns data one cycle after each read strobe. The expected bytes are rebuilt from the same address formula the model uses.

// File: rtl/wws_pkg.sv
package wws_pkg;
    localparam logic [15:0] READ_CMD_CODE = 16'h0006;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_RD_LO,
        ENG_RD_HI,
        ENG_CAPTURE,
        ENG_SEND
    } eng_state_e;
endpackage

// File: rtl/wws_cmd_parse.sv
module wws_cmd_parse
    import wws_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take,
    input  logic [15:0] word,
    output logic        req_valid,
    output logic [31:0] req_addr,
    output logic [31:0] req_cnt
);
    typedef struct packed {
        logic [2:0]  slot;
        logic [15:0] addr_hi;
        logic [15:0] addr_lo;
        logic [15:0] cnt_hi;
        logic        req;
        logic [31:0] addr;
        logic [31:0] cnt;
    } parse_t;

    parse_t pr_d, pr_q;

    always_comb begin
        pr_d     = pr_q;
        pr_d.req = 1'b0;
        if (take) begin
            case (pr_q.slot)
                3'd0: if (word == READ_CMD_CODE) pr_d.slot = 3'd1;
                3'd1: begin pr_d.addr_hi = word; pr_d.slot = 3'd2; end
                3'd2: begin pr_d.addr_lo = word; pr_d.slot = 3'd3; end
                3'd3: begin pr_d.cnt_hi  = word; pr_d.slot = 3'd4; end
                3'd4: begin
                    pr_d.req  = 1'b1;
                    pr_d.addr = {pr_q.addr_hi, pr_q.addr_lo};
                    pr_d.cnt  = {pr_q.cnt_hi, word};
                    pr_d.slot = 3'd0;
                end
                default: pr_d.slot = 3'd0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pr_q <= '0;
        else        pr_q <= pr_d;
    end

    assign req_valid = pr_q.req;
    assign req_addr  = pr_q.addr;
    assign req_cnt   = pr_q.cnt;
endmodule

// File: rtl/wws_fetch_pack.sv
module wws_fetch_pack
    import wws_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    input  logic [31:0]       req_cnt,
    output logic              idle,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_byte,
    output logic              out_last,
    output logic              err_pulse
);
    localparam int UNIT_W  = 2 * WORD_W;
    localparam int N_BYTES = UNIT_W / 8;
    localparam int IDX_W   = $clog2(N_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_BYTES - 1);

    typedef struct packed {
        eng_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [30:0]       pairs;
        logic [UNIT_W-1:0] unit;
        logic [IDX_W-1:0]  idx;
        logic              err;
    } eng_t;

    eng_t en_d, en_q;

    logic [31-ADDR_W:0] unused_addr_hi;
    assign unused_addr_hi = req_addr[31:ADDR_W];

    always_comb begin
        en_d     = en_q;
        en_d.err = 1'b0;
        case (en_q.st)
            ENG_IDLE: begin
                if (req_valid) begin
                    if (req_cnt[0]) begin
                        en_d.err = 1'b1;
                    end else if (req_cnt != 32'd0) begin
                        en_d.pairs = req_cnt[31:1];
                        en_d.addr  = req_addr[ADDR_W-1:0];
                        en_d.st    = ENG_RD_LO;
                    end
                end
            end
            ENG_RD_LO: en_d.st = ENG_RD_HI;
            ENG_RD_HI: begin
                en_d.unit[WORD_W-1:0] = mem_rd_data;
                en_d.st               = ENG_CAPTURE;
            end
            ENG_CAPTURE: begin
                en_d.unit[UNIT_W-1:WORD_W] = mem_rd_data;
                en_d.idx                   = '0;
                en_d.st                    = ENG_SEND;
            end
            ENG_SEND: begin
                if (out_ready) begin
                    if (en_q.idx == LAST_IDX) begin
                        en_d.pairs = en_q.pairs - 31'd1;
                        en_d.addr  = en_q.addr + ADDR_W'(2);
                        en_d.st    = (en_q.pairs == 31'd1) ? ENG_IDLE : ENG_RD_LO;
                    end else begin
                        en_d.idx = en_q.idx + IDX_W'(1);
                    end
                end
            end
            default: en_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign idle      = (en_q.st == ENG_IDLE);
    assign mem_rd_en = (en_q.st == ENG_RD_LO) || (en_q.st == ENG_RD_HI);
    assign mem_addr  = (en_q.st == ENG_RD_HI) ? en_q.addr + ADDR_W'(1) : en_q.addr;
    assign out_valid = (en_q.st == ENG_SEND);
    assign out_byte  = en_q.unit[{en_q.idx, 3'b000} +: 8];
    assign out_last  = out_valid && (en_q.idx == LAST_IDX) && (en_q.pairs == 31'd1);
    assign err_pulse = en_q.err;
endmodule

// File: rtl/wide_word_read_streamer.sv
module wide_word_read_streamer #(
    parameter int ADDR_W = 18,
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [15:0]       cmd_word,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_byte,
    output logic              out_last,
    output logic              err_pulse
);
    logic        req_valid;
    logic [31:0] req_addr;
    logic [31:0] req_cnt;
    logic        eng_idle;

    assign cmd_ready = eng_idle && !req_valid;

    wws_cmd_parse u_parse (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (cmd_valid && cmd_ready),
        .word      (cmd_word),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_cnt   (req_cnt)
    );

    wws_fetch_pack #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_cnt     (req_cnt),
        .idle        (eng_idle),
        .mem_rd_en   (mem_rd_en),
        .mem_addr    (mem_addr),
        .mem_rd_data (mem_rd_data),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_byte    (out_byte),
        .out_last    (out_last),
        .err_pulse   (err_pulse)
    );
endmodule

// File: rtl/wws_checker.sv
module wws_checker #(
    parameter int ADDR_W = 18,
    parameter int WORD_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [15:0]       cmd_word,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_rd_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_byte,
    input logic              out_last,
    input logic              err_pulse
);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_last));

    p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !cmd_ready);

    p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> !out_valid && !mem_rd_en);

    p_err_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);

    p_last_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    p_pair_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en && $past(mem_rd_en) |-> mem_addr == $past(mem_addr) + ADDR_W'(1));

    p_no_send_during_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !out_valid);
endmodule

bind wide_word_read_streamer wws_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/wide_word_read_streamer_test.sv
module wide_word_read_streamer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [15:0] cmd_word = '0;
    logic        mem_rd_en;
    logic [17:0] mem_addr;
    logic [35:0] mem_rd_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_byte;
    logic        out_last;
    logic        err_pulse;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wide_word_read_streamer uut (.*);

    function automatic logic [35:0] mem_val(input logic [17:0] a);
        return {a ^ 18'h2A5C3, a + 18'h01234};
    endfunction

    always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_val(mem_addr);

    function automatic logic [7:0] exp_byte(input logic [17:0] base, input int j);
        logic [71:0] u;
        logic [17:0] a;
        a = base + 18'(2 * (j / 9));
        u = {mem_val(a + 18'd1), mem_val(a)};
        return u[8*(j%9) +: 8];
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic send_word(input logic [15:0] w);
        cmd_valid = 1'b1;
        cmd_word  = w;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_cmd(input logic [31:0] a, input logic [31:0] n);
        send_word(16'h0006);
        send_word(a[31:16]);
        send_word(a[15:0]);
        send_word(n[31:16]);
        send_word(n[15:0]);
    endtask

    // R1 R3 R4 R8 R9: full read with byte, last and timing checks
    task automatic do_read(input logic [31:0] a, input int n, input bit stall);
        int wait_n = 0;
        int got = 0;
        int stall_cnt = 0;
        int gap = 0;
        bit held = 0;
        logic [7:0] held_byte = '0;
        bit done = 0;
        send_cmd(a, 32'(n));
        while (!out_valid && wait_n < 20) begin
            @(negedge clk);
            wait_n++;
        end
        chk(wait_n == 4, "R9 first byte latency", wait_n, 4);
        chk(!cmd_ready, "R2 busy while streaming", cmd_ready, 0);
        while (!done && got < 100000) begin
            out_ready = stall ? ((stall_cnt % 3) != 0) : 1'b1;
            stall_cnt++;
            if (out_valid) begin
                if (held) chk(out_byte == held_byte, "R8 hold under stall", out_byte, held_byte);
                if (got > 0 && got % 9 == 0 && gap != 0)
                    chk(gap == 3, "R9 pair gap", gap, 3);
                gap = 0;
                if (out_ready) begin
                    chk(out_byte == exp_byte(a[17:0], got), "R3 R7 byte value", out_byte,
                        exp_byte(a[17:0], got));
                    chk(out_last == (got == n*9/2 - 1), "R4 last flag", out_last,
                        (got == n*9/2 - 1));
                    if (out_last) done = 1;
                    got++;
                    held = 0;
                end else begin
                    held = 1;
                    held_byte = out_byte;
                end
            end else begin
                gap++;
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(got == n*9/2, "R3 byte count", got, n*9/2);
        chk(cmd_ready, "R2 ready after response", cmd_ready, 1);
    endtask

    task automatic t_reset;
        chk(cmd_ready == 1'b1, "R10 cmd_ready", cmd_ready, 1);
        chk({out_valid, out_last, mem_rd_en, err_pulse} == 4'b0, "R10 outputs idle",
            {out_valid, out_last, mem_rd_en, err_pulse}, 0);
    endtask

    task automatic t_odd;
        bit seen = 0;
        send_cmd(32'h0000_0010, 32'd3);
        chk(err_pulse == 1'b0, "R5 no pulse at handshake edge", err_pulse, 0);
        @(negedge clk);
        chk(err_pulse == 1'b1, "R5 error pulse", err_pulse, 1);
        @(negedge clk);
        chk(err_pulse == 1'b0, "R5 pulse one cycle", err_pulse, 0);
        for (int i = 0; i < 12; i++) begin
            if (out_valid || mem_rd_en || err_pulse) seen = 1;
            @(negedge clk);
        end
        chk(!seen, "R5 odd count silent", seen, 0);
    endtask

    task automatic t_zero;
        bit seen = 0;
        send_cmd(32'h0000_0020, 32'd0);
        for (int i = 0; i < 12; i++) begin
            if (out_valid || mem_rd_en || err_pulse) seen = 1;
            @(negedge clk);
        end
        chk(!seen, "R6 zero count silent", seen, 0);
        chk(cmd_ready, "R6 ready after zero count", cmd_ready, 1);
    endtask

    task automatic t_bad_code;
        send_word(16'h0007);
        send_word(16'h1234);
        do_read(32'h0000_0100, 2, 0);   // R1: stray words dropped
    endtask

    initial begin
        #1;
        t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        do_read(32'h0000_0004, 2, 0);
        do_read(32'h0000_0000, 8, 1);
        do_read(32'h0003_FFFF, 2, 0);    // R7 wrap
        do_read(32'hABC4_0003, 4, 1);    // R7 upper bits ignored
        t_odd();
        t_zero();
        t_bad_code();
        do_read(32'h0001_2345, 120, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule